// File: doc/BRIEF.md
# Flash Erase and Program Sequencer

This block is a host-side engine that takes over a byte-wide flash device through a simple command bus. The bus has one write strobe, one read strobe, an address and separate write and read data bytes. After a single start pulse, the engine runs the whole job without software help. It first reads the device identifier and compares it against expected values. It then erases every block, checking each block by reading it back. Finally it programs the whole device from a local source buffer, one byte at a time, and checks the device status after each byte.

The device answers a read strobe with data one cycle later. The source buffer is read through an address output with combinational data returned. After every erase and every programmed byte, the engine writes the status-query command and keeps reading until the device reports ready. A programmable limit caps the number of those reads. The result stays visible until the next start: either `done`, or a non-zero error code together with the address where the run stopped. A separate flag warns when the manufacturer byte has even parity, and the last captured status byte is kept on an output.

Top module: `flash_seq`

## Requirements
- R1: While reset is asserted, and after it is released until the first start, `busy`, `done`, `fl_we` and `fl_re` are 0 and `err_code` is 0. Asserting reset in the middle of a run returns the block to this state at once.
- R2: A run begins with the writes 0xFF and then 0x90, and each of these writes is followed by at least SETTLE cycles with no bus access. The engine then reads offsets 0 and 1 and writes 0xFF again. The write and read strobes are never high together.
- R3: If the byte read at offset 0 differs from `exp_mfr`, or the byte at offset 1 differs from `exp_dev`, the run ends with `err_code`=1 (identifier mismatch). In that case the bus shows no accesses beyond the three writes and two reads of the probe.
- R4: `id_parity_warn` is 1 after a probe whose manufacturer byte has an even number of ones, and 0 when that number is odd.
- R5: For every block, in ascending block order, the engine writes 0x50, 0x20 and 0xD0 to an address inside that block. Every block has been erased before the first program command (0x40) appears.
- R6: Each wait for completion writes 0x70, then reads until bit 7 of the returned byte is 1. It then writes 0xFF and keeps the final byte on `last_status`.
- R7: After each block erase, every byte of that block is read back. The first value other than 0xFF ends the run with `err_code`=2 and `err_addr` set to that byte's address.
- R8: Programming writes 0x40 and then the source byte `src_data` (for `src_addr` equal to the target address) to each address from 0 to the last, in ascending order. After a successful run, the device contents equal the source buffer.
- R9: If the final status byte of a wait has bit 5 set, the run ends with `err_code`=3. Otherwise, if it has bit 4 set, the run ends with `err_code`=4. In both cases `err_addr` holds the current address: the block base during an erase, or the byte address during programming.
- R10: If bit 7 is still 0 after `poll_limit` status reads, the run ends with `err_code`=5 and no further read is issued.
- R11: A run that finishes without error ends with `busy`=0, `done`=1 and `err_code`=0. `done` is never 1 while `busy` is 1 or while `err_code` is non-zero. The result holds until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a run while idle |
| exp_mfr | input | 8 | Expected manufacturer identifier |
| exp_dev | input | 8 | Expected device identifier |
| poll_limit | input | POLL_W | Maximum number of status reads per wait |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | 8 | Command or data byte written |
| fl_rdata | input | 8 | Byte returned one cycle after a read strobe |
| src_addr | output | ADDR_W | Source buffer address |
| src_data | input | 8 | Source buffer byte at `src_addr` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run completed without error |
| err_code | output | 3 | 0 none, 1 id mismatch, 2 erase verify, 3 erase status, 4 program status, 5 timeout |
| err_addr | output | ADDR_W | Address at which a failed run stopped |
| id_parity_warn | output | 1 | Manufacturer byte had even parity |
| last_status | output | 8 | Final status byte of the latest wait |

## Verification
The bench builds the engine with ADDR_W=6, BLK_W=4 and SETTLE=4. This gives a 64-byte device of four 16-byte blocks, so every block and every byte is erased, verified and programmed within a short run. It also lets a single injected stuck byte or status fault land in a chosen block or at a chosen address. With `poll_limit` set to 5 in the hang case, the exact count of status reads before the timeout can be checked. A generous limit in the other cases keeps normal busy periods from being cut off.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [4:0] {
    ST_IDLE, ST_PRST, ST_PSET1, ST_PID, ST_PSET2, ST_PRD0, ST_PRD1, ST_PCAP,
    ST_PEXIT, ST_ECLR, ST_EERS, ST_ECNF, ST_WCMD, ST_WRD, ST_WCAP, ST_WFIN,
    ST_VRD, ST_VCAP, ST_GCMD, ST_GDAT
  } seq_state_t;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_IDMIS   = 3'd1,
    RES_VERIFY  = 3'd2,
    RES_ERSTAT  = 3'd3,
    RES_PGSTAT  = 3'd4,
    RES_TIMEOUT = 3'd5
  } seq_result_t;

  localparam logic [7:0] OP_ARRAY   = 8'hFF;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_CLRSTAT = 8'h50;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_PROGRAM = 8'h40;

  localparam int RDY_BIT = 7;
  localparam int EER_BIT = 5;
  localparam int PER_BIT = 4;

endpackage

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] load_val,
  output logic         zero,
  output logic         last
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load | dec;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (dec && cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
  assign last = (cnt_q[W-1:1] == '0);
endmodule

// File: rtl/flash_seq_idchk.sv
module flash_seq_idchk (
  input  logic [7:0] id_mfr,
  input  logic [7:0] id_dev,
  input  logic [7:0] want_mfr,
  input  logic [7:0] want_dev,
  output logic       match,
  output logic       par_odd
);
  assign match   = (id_mfr == want_mfr) && (id_dev == want_dev);
  assign par_odd = ^id_mfr;
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BLK_W  = 4,
  parameter int SETTLE = 4,
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        exp_mfr,
  input  logic [7:0]        exp_dev,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              fl_we,
  output logic              fl_re,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  input  logic [7:0]        fl_rdata,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [7:0]        src_data,
  output logic              busy,
  output logic              done,
  output logic [2:0]        err_code,
  output logic [ADDR_W-1:0] err_addr,
  output logic              id_parity_warn,
  output logic [7:0]        last_status
);
  localparam logic [ADDR_W-1:0] ADDR_ONE   = ADDR_W'(1);
  localparam logic [POLL_W-1:0] SETTLE_VAL = POLL_W'(SETTLE);

  seq_state_t        state_q, state_d;
  seq_result_t       err_q, err_d;
  logic [ADDR_W-1:0] addr_q, addr_d, eaddr_q, eaddr_d;
  logic [7:0]        id0_q, id0_d, id1_q, id1_d, stat_q, stat_d;
  logic              pgm_q, pgm_d, done_q, done_d, warn_q, warn_d;
  logic              t_load, t_dec, t_zero, t_last;
  logic [POLL_W-1:0] t_val;
  logic              id_match, id_par_odd;
  logic              blk_end, dev_end;

  flash_seq_timer #(.W(POLL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .dec(t_dec),
    .load_val(t_val), .zero(t_zero), .last(t_last)
  );

  flash_seq_idchk u_idchk (
    .id_mfr(id0_q), .id_dev(id1_q), .want_mfr(exp_mfr), .want_dev(exp_dev),
    .match(id_match), .par_odd(id_par_odd)
  );

  assign blk_end = (addr_q[BLK_W-1:0] == '1);
  assign dev_end = (addr_q == '1);

  always_comb begin
    state_d = state_q;  addr_d = addr_q;  eaddr_d = eaddr_q;
    id0_d   = id0_q;    id1_d  = id1_q;   stat_d  = stat_q;
    pgm_d   = pgm_q;    err_d  = err_q;   done_d  = done_q;  warn_d = warn_q;
    fl_we = 1'b0;  fl_re = 1'b0;  fl_wdata = OP_ARRAY;  fl_addr = addr_q;
    t_load = 1'b0; t_dec = 1'b0;  t_val = SETTLE_VAL;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_PRST; addr_d = '0; err_d = RES_OK; done_d = 1'b0;
        warn_d = 1'b0; eaddr_d = '0;
      end
      ST_PRST:  begin fl_we = 1'b1; fl_addr = '0; t_load = 1'b1; state_d = ST_PSET1; end
      ST_PSET1: if (t_zero) state_d = ST_PID; else t_dec = 1'b1;
      ST_PID:   begin
        fl_we = 1'b1; fl_addr = '0; fl_wdata = OP_IDENT; t_load = 1'b1; state_d = ST_PSET2;
      end
      ST_PSET2: if (t_zero) state_d = ST_PRD0; else t_dec = 1'b1;
      ST_PRD0:  begin fl_re = 1'b1; fl_addr = '0; state_d = ST_PRD1; end
      ST_PRD1:  begin fl_re = 1'b1; fl_addr = ADDR_ONE; id0_d = fl_rdata; state_d = ST_PCAP; end
      ST_PCAP:  begin id1_d = fl_rdata; state_d = ST_PEXIT; end
      ST_PEXIT: begin
        fl_we = 1'b1; fl_addr = '0; warn_d = ~id_par_odd; addr_d = '0;
        if (!id_match) begin err_d = RES_IDMIS; state_d = ST_IDLE; end
        else state_d = ST_ECLR;
      end
      ST_ECLR: begin fl_we = 1'b1; fl_wdata = OP_CLRSTAT; state_d = ST_EERS; end
      ST_EERS: begin fl_we = 1'b1; fl_wdata = OP_ERASE;   state_d = ST_ECNF; end
      ST_ECNF: begin
        fl_we = 1'b1; fl_wdata = OP_CONFIRM; pgm_d = 1'b0; state_d = ST_WCMD;
      end
      ST_WCMD: begin
        fl_we = 1'b1; fl_wdata = OP_STATUS; t_load = 1'b1; t_val = poll_limit; state_d = ST_WRD;
      end
      ST_WRD: begin fl_re = 1'b1; state_d = ST_WCAP; end
      ST_WCAP: begin
        stat_d = fl_rdata;
        if (fl_rdata[RDY_BIT]) state_d = ST_WFIN;
        else if (t_last) begin err_d = RES_TIMEOUT; eaddr_d = addr_q; state_d = ST_IDLE; end
        else begin t_dec = 1'b1; state_d = ST_WRD; end
      end
      ST_WFIN: begin
        fl_we = 1'b1;
        if (stat_q[EER_BIT]) begin err_d = RES_ERSTAT; eaddr_d = addr_q; state_d = ST_IDLE; end
        else if (stat_q[PER_BIT]) begin err_d = RES_PGSTAT; eaddr_d = addr_q; state_d = ST_IDLE; end
        else if (!pgm_q) state_d = ST_VRD;
        else if (dev_end) begin done_d = 1'b1; state_d = ST_IDLE; end
        else begin addr_d = addr_q + ADDR_ONE; state_d = ST_GCMD; end
      end
      ST_VRD: begin fl_re = 1'b1; state_d = ST_VCAP; end
      ST_VCAP: begin
        if (fl_rdata != 8'hFF) begin err_d = RES_VERIFY; eaddr_d = addr_q; state_d = ST_IDLE; end
        else if (blk_end) begin
          addr_d  = addr_q + ADDR_ONE;
          state_d = dev_end ? ST_GCMD : ST_ECLR;
        end else begin addr_d = addr_q + ADDR_ONE; state_d = ST_VRD; end
      end
      ST_GCMD: begin fl_we = 1'b1; fl_wdata = OP_PROGRAM; state_d = ST_GDAT; end
      ST_GDAT: begin fl_we = 1'b1; fl_wdata = src_data; pgm_d = 1'b1; state_d = ST_WCMD; end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; err_q <= RES_OK; addr_q <= '0; eaddr_q <= '0;
      id0_q <= '0; id1_q <= '0; stat_q <= '0; pgm_q <= 1'b0;
      done_q <= 1'b0; warn_q <= 1'b0;
    end else begin
      state_q <= state_d; err_q <= err_d; addr_q <= addr_d; eaddr_q <= eaddr_d;
      id0_q <= id0_d; id1_q <= id1_d; stat_q <= stat_d; pgm_q <= pgm_d;
      done_q <= done_d; warn_q <= warn_d;
    end
  end

  assign src_addr       = addr_q;
  assign busy           = (state_q != ST_IDLE);
  assign done           = done_q;
  assign err_code       = err_q;
  assign err_addr       = eaddr_q;
  assign id_parity_warn = warn_q;
  assign last_status    = stat_q;
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [2:0] err_code,
  input logic       fl_we,
  input logic       fl_re
);
  p_bus_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fl_we && !fl_re));

  p_start_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  p_done_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err_code == 3'd0 && !busy));

  p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(err_code) && $stable(done)));
endmodule

bind flash_seq flash_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err_code(err_code), .fl_we(fl_we), .fl_re(fl_re)
);

// File: tb/flash_seq_test.sv
module flash_seq_test;
  localparam int AW = 6, BLKW = 4, SETTLE = 4, PW = 16;
  localparam int NBYTE = 1 << AW, NBLK = 1 << (AW - BLKW), LOGN = 1024;
  localparam logic [AW-1:0] STUCK_A = 6'h25, PERR_A = 6'h13;
  // {dev_mfr, dev_id, exp_mfr, exp_dev, inject, expected err}
  // inject: 0 none, 1 stuck byte, 2 erase status fault, 3 program status fault, 4 never ready
  localparam logic [37:0] VEC [7] = '{
    {8'h89, 8'hA6, 8'h89, 8'hA6, 3'd0, 3'd0},
    {8'h89, 8'hA6, 8'h89, 8'hA7, 3'd0, 3'd1},
    {8'h89, 8'hA6, 8'h89, 8'hA6, 3'd1, 3'd2},
    {8'h89, 8'hA6, 8'h89, 8'hA6, 3'd2, 3'd3},
    {8'h89, 8'hA6, 8'h89, 8'hA6, 3'd3, 3'd4},
    {8'h89, 8'hA6, 8'h89, 8'hA6, 3'd4, 3'd5},
    {8'h88, 8'hA6, 8'h88, 8'hA6, 3'd0, 3'd0}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, fl_we, fl_re, busy, done, warn;
  logic [7:0] exp_mfr, exp_dev, fl_wdata, fl_rdata, src_data, last_status;
  logic [PW-1:0] poll_limit;
  logic [AW-1:0] fl_addr, src_addr, err_addr;
  logic [2:0] err_code;

  flash_seq #(.ADDR_W(AW), .BLK_W(BLKW), .SETTLE(SETTLE), .POLL_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .exp_mfr(exp_mfr), .exp_dev(exp_dev),
    .poll_limit(poll_limit), .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .src_addr(src_addr), .src_data(src_data),
    .busy(busy), .done(done), .err_code(err_code), .err_addr(err_addr),
    .id_parity_warn(warn), .last_status(last_status)
  );

  function automatic logic [7:0] src_val(int i);
    return 8'((i * 7 + 3) & 8'hFF);
  endfunction
  assign src_data = src_val(int'(src_addr));

  // ---- device model ----
  logic [7:0] dev_mfr, dev_id;
  int inj;
  logic mdl_clr;
  logic [7:0] mem [NBYTE];
  int mode, busy_cnt, rd_n, lg_n, cyc;
  logic e_err, p_err, pend_e, pend_p;
  logic [7:0] lg_d [LOGN];
  logic lg_dat [LOGN];
  int lg_cyc [LOGN];

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (mdl_clr) begin
      for (int j = 0; j < NBYTE; j++) mem[j] = 8'h5A ^ 8'(j);
      mode = 0; busy_cnt = 0; rd_n = 0; lg_n = 0;
      e_err = 0; p_err = 0; pend_e = 0; pend_p = 0;
    end else begin
      if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
      if (fl_re) begin
        rd_n = rd_n + 1;
        if (mode == 0) fl_rdata <= mem[fl_addr];
        else if (mode == 1) fl_rdata <= (fl_addr == 0) ? dev_mfr : (fl_addr == 1) ? dev_id : 8'h00;
        else fl_rdata <= {(inj != 4 && busy_cnt == 0), 1'b0, e_err, p_err, 4'b0};
      end
      if (fl_we) begin
        if (lg_n < LOGN) begin
          lg_d[lg_n] = fl_wdata; lg_dat[lg_n] = pend_p; lg_cyc[lg_n] = cyc; lg_n = lg_n + 1;
        end
        if (pend_p) begin
          mem[fl_addr] = mem[fl_addr] & fl_wdata; pend_p = 0; busy_cnt = 3; mode = 2;
          if (inj == 3 && fl_addr == PERR_A) p_err = 1;
        end else begin
          logic was_e;
          was_e = pend_e; pend_e = (fl_wdata == 8'h20);
          case (fl_wdata)
            8'hFF: mode = 0;
            8'h90: mode = 1;
            8'h70: mode = 2;
            8'h50: begin e_err = 0; p_err = 0; end
            8'h40: pend_p = 1;
            8'hD0: if (was_e) begin
              for (int j = 0; j < NBYTE; j++)
                if ((j >> BLKW) == (int'(fl_addr) >> BLKW)) mem[j] = 8'hFF;
              if (inj == 1 && (STUCK_A >> BLKW) == (fl_addr >> BLKW)) mem[STUCK_A] = 8'h7F;
              if (inj == 2) e_err = 1;
              busy_cnt = 5; mode = 2;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // ---- checking ----
  int n_chk = 0, n_bad = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string err_req(int e);
    case (e)
      1: return "R3"; 2: return "R7"; 3, 4: return "R9"; 5: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic run(input logic [37:0] v);
    @(negedge clk);
    {dev_mfr, dev_id, exp_mfr, exp_dev} = v[37:6];
    inj = int'(v[5:3]);
    poll_limit = (inj == 4) ? PW'(5) : PW'(200);
    mdl_clr = 1'b1;
    @(negedge clk); mdl_clr = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 20000 && busy; k++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mdl_clr = 1'b1; inj = 0; cyc = 0;
    exp_mfr = 8'h89; exp_dev = 8'hA6; dev_mfr = 8'h89; dev_id = 8'hA6; poll_limit = PW'(200);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && err_code == 0 && !fl_we && !fl_re, "R1 in reset", {busy, done, err_code}, 0);
    rst_n = 1'b1;
    @(negedge clk); mdl_clr = 1'b0;
    @(negedge clk);
    check(!busy && !done && err_code == 0 && !fl_we && !fl_re, "R1 after release", {busy, done, err_code}, 0);

    for (int t = 0; t < 7; t++) begin
      int ee;
      ee = int'(VEC[t][2:0]);
      run(VEC[t]);
      check(err_code == 3'(ee), err_req(ee), err_code, ee);
      check(done == (ee == 0) && !busy, "R11 done", {busy, done}, (ee == 0) ? 1 : 0);
      case (t)
        0: begin
          int nd0, nfirst40, nlast_d0, n40;
          bit ok5, ok6, ok8;
          check(lg_d[0] == 8'hFF && lg_d[1] == 8'h90 && lg_d[2] == 8'hFF, "R2 order",
                {lg_d[0], lg_d[1], lg_d[2]}, 24'hFF90FF);
          check(lg_cyc[1] - lg_cyc[0] > SETTLE && lg_cyc[2] - lg_cyc[1] > SETTLE + 2,
                "R2 settle", lg_cyc[1] - lg_cyc[0], SETTLE + 1);
          check(warn == 1'b0, "R4 odd", warn, 0);
          nd0 = 0; nfirst40 = -1; nlast_d0 = -1; n40 = 0; ok5 = 1; ok6 = 1;
          for (int i = 0; i < lg_n; i++) begin
            if (!lg_dat[i] && lg_d[i] == 8'hD0) begin
              ok5 &= (i >= 2 && lg_d[i-1] == 8'h20 && lg_d[i-2] == 8'h50);
              nd0++; nlast_d0 = i;
            end
            if (!lg_dat[i] && lg_d[i] == 8'h40) begin
              n40++; if (nfirst40 < 0) nfirst40 = i;
            end
            if (!lg_dat[i] && lg_d[i] == 8'h70)
              ok6 &= (i + 1 < lg_n && lg_d[i+1] == 8'hFF && !lg_dat[i+1]);
          end
          check(ok5 && nd0 == NBLK && nlast_d0 < nfirst40, "R5 erase all first", nd0, NBLK);
          check(ok6, "R6 status then reset", ok6, 1);
          check(last_status == 8'h80, "R6 last status", last_status, 8'h80);
          ok8 = 1;
          for (int i = 0; i < NBYTE; i++) ok8 &= (mem[i] == src_val(i));
          check(ok8 && n40 == NBYTE, "R8 contents", n40, NBYTE);
        end
        1: check(lg_n == 3 && rd_n == 2, "R3 no erase", lg_n * 16 + rd_n, 3 * 16 + 2);
        2: check(err_addr == STUCK_A, "R7 err_addr", err_addr, STUCK_A);
        3: check(err_addr == 0 && last_status[5], "R9 erase addr", err_addr, 0);
        4: check(err_addr == PERR_A && last_status[4], "R9 program addr", err_addr, PERR_A);
        5: check(rd_n == 2 + 5, "R10 read count", rd_n, 7);
        6: check(warn == 1'b1, "R4 even", warn, 1);
        default: ;
      endcase
    end

    // R1: reset in the middle of a run
    @(negedge clk);
    {dev_mfr, dev_id, exp_mfr, exp_dev} = {8'h89, 8'hA6, 8'h89, 8'hA6};
    inj = 0; poll_limit = PW'(200);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    check(busy, "R1 run active", busy, 1);
    rst_n = 1'b0;
    #1;
    check(!busy && !done && err_code == 0 && !fl_we && !fl_re, "R1 mid-run reset",
          {busy, done, err_code}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !fl_we && !fl_re, "R1 stays idle", busy, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule